// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns one request from a processor core into a complete external transfer on a bus where a 20-bit address and 16-bit data share pins. Each bus cycle takes one clock per T-state and runs T1, T2, T3, zero or more wait states (Tw), then T4.

In T1 the low 16 address bits go out on the shared lines. The top four address bits go out on a separate group of four lines, and a single-cycle address-latch pulse marks that state. From T2 onward the low lines carry write data or are released so a read can return its data. The upper group then carries a status code that names the segment in use.

The block also drives:
- the read and write strobes,
- an active-low data enable that is offset by half a clock,
- the transfer direction,
- the memory/IO select,
- the byte-high enable.

The wait states follow the READY input. Another bus master can take the bus with a hold request. The block grants it only at a cycle boundary and then releases every bus and control output, except the address-latch strobe.

The core presents a request with `req_valid` and sees it taken on a clock edge where `req_ready` is high. For a read, the data returns on `rd_data` with a one-cycle `rd_valid` pulse during T4. Write data must already sit on the byte lanes that the transfer uses.

Top module: `mbus_seq`

## Requirements
- R1: While `rst_n` is low and after it rises, the block is idle: `ale` 0, `rd_n`, `wr_n` and `data_en_n` 1, `ad_oe` 0, `hold_ack` 0, `ctl_oe` 1, and `req_ready` 1 when `hold_req` is low.
- R2: `req_ready` is high only in the idle state or in T4, and only while `hold_req` is low. A request taken on an edge starts T1 in the next cycle. `ale` is high for exactly that one T1 cycle.
- R3: In T1, `ad_oe` is 1 and `ad_out` equals address bits 15..0. `a_hi` equals address bits 19..16 for a memory cycle and 0000 for an IO cycle.
- R4: From T2 through T4, `a_hi` carries the status code. Bit 3 and bit 2 are 0, and bits 1..0 hold the segment code: 00 extra, 01 stack, 10 code or none, 11 data.
- R5: In T1 the lane code {`bhe_n`, `ad_out[0]`} is 00 for a word at an even address, 01 for a byte at an odd address and 10 for a byte at an even address. `bhe_n` is 1 outside a cycle.
- R6: In a read, `rd_n` is low in T2, T3 and every Tw, and `ad_oe` is 0 from T2. The `ad_in` value present at the edge that ends the last T3/Tw appears on `rd_data`, with `rd_valid` high, in T4.
- R7: In a write, `wr_n` is low in T2, T3 and every Tw. `ad_oe` stays 1 and `ad_out` equals the write data from T2 through T4. `rd_n` and `wr_n` are never low together.
- R8: `data_en_n` falls at the falling clock edge inside T2 and rises at the falling clock edge inside T4. `dir_tx` is 1 for writes and 0 for reads from T1 through T4.
- R9: `mem_sel` is 1 for memory and 0 for IO. In idle or T4, when a request is being taken, it already shows that request's value. Through T1 to the last Tw it shows the current cycle's value.
- R10: READY is sampled on the edge that ends T3 and on the edge that ends each Tw. A low sample inserts one more Tw, so a cycle has exactly two strobe cycles plus one per low sample.
- R11: A hold request seen in idle or T4 moves the block to the hold state on the next edge, taking priority over a pending request. A hold raised during T1 to Tw is granted only after that cycle's T4.
- R12: While `hold_ack` is 1, `ad_oe` and `ctl_oe` are 0, `ale` stays 0 and no request is taken. On the edge after `hold_req` falls, `hold_ack` drops and `ctl_oe` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one period per T-state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core has a request pending |
| req_ready | output | 1 | Request is taken on this edge when valid |
| req_addr | input | 20 | Physical address of the transfer |
| req_wdata | input | 16 | Write data, already lane aligned |
| req_write | input | 1 | 1 write, 0 read |
| req_mem | input | 1 | 1 memory space, 0 IO space |
| req_word | input | 1 | 1 word transfer, 0 byte transfer |
| req_seg | input | 2 | Segment code shown as status |
| rd_data | output | 16 | Captured read data |
| rd_valid | output | 1 | One-cycle pulse in T4 of a read |
| ad_out | output | 16 | Shared address/data lines, outgoing value |
| ad_in | input | 16 | Shared address/data lines, incoming value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| a_hi | output | 4 | Upper address in T1, status afterwards |
| bhe_n | output | 1 | Active-low high byte lane enable |
| ale | output | 1 | Address latch strobe, high in T1 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| data_en_n | output | 1 | Active-low transceiver enable |
| dir_tx | output | 1 | 1 when the block transmits |
| mem_sel | output | 1 | 1 memory, 0 IO |
| ready | input | 1 | Slave ready, sampled at the end of T3/Tw |
| hold_req | input | 1 | Another master asks for the bus (already synchronized) |
| hold_ack | output | 1 | Bus handed over |
| ctl_oe | output | 1 | Drive enable for a_hi, strobes and control lines |

## Verification
The bench runs bus cycles that differ in direction, space, width, alignment, segment code and wait-state count. It also sends two requests back to back, so the second is taken in the first one's T4. A sequencer that sampled READY one edge early or late would show the wrong number of strobe cycles. One that latched the shared lines at the wrong edge would return stale read data. One that left the upper address bits on during an IO cycle, or swapped the lane code, would fail the T1 checks.

A hold request is raised in idle and also in the middle of a read that has wait states, with a second request already pending. A design that granted the bus mid-cycle, let the request win the boundary, or kept driving the shared lines while granted would show it on `hold_ack`, `ctl_oe` or a spurious `ale`.

// File: rtl/mbus_pkg.sv
`timescale 1ns/1ps
package mbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } bus_st_e;

  // a new request or a hold grant may start only here
  function automatic logic is_boundary(input bus_st_e st);
    return (st == ST_IDLE) || (st == ST_T4);
  endfunction

  // states in which a read or write strobe is active
  function automatic logic in_strobe(input bus_st_e st);
    return (st == ST_T2) || (st == ST_T3) || (st == ST_TW);
  endfunction

  // states after T1 that still belong to the cycle
  function automatic logic in_data(input bus_st_e st);
    return in_strobe(st) || (st == ST_T4);
  endfunction

  function automatic logic in_cycle(input bus_st_e st);
    return (st == ST_T1) || in_data(st);
  endfunction

  // high lane is used by any word and by a byte at an odd address
  function automatic logic lane_bhe_n(input logic word, input logic a0);
    return ~(word | a0);
  endfunction

endpackage

// File: rtl/mbus_fsm.sv
`timescale 1ns/1ps
module mbus_fsm
  import mbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    hold_req,
  input  logic    ready,
  output bus_st_e state,
  output logic    req_ready,
  output logic    accept,
  output logic    sample_ev
);

  bus_st_e nxt;

  assign req_ready = is_boundary(state) && !hold_req;
  assign accept    = req_ready && req_valid;
  assign sample_ev = ((state == ST_T3) || (state == ST_TW)) && ready;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE, ST_T4: begin
        if (hold_req)       nxt = ST_HOLD;
        else if (req_valid) nxt = ST_T1;
        else                nxt = ST_IDLE;
      end
      ST_T1:   nxt = ST_T2;
      ST_T2:   nxt = ST_T3;
      ST_T3,
      ST_TW:   nxt = ready ? ST_T4 : ST_TW;
      ST_HOLD: nxt = hold_req ? ST_HOLD : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/mbus_reqreg.sv
`timescale 1ns/1ps
module mbus_reqreg #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              sample_ev,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic              req_word,
  input  logic [1:0]        req_seg,
  input  logic [DATA_W-1:0] ad_in,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata,
  output logic              cur_write,
  output logic              cur_mem,
  output logic              cur_word,
  output logic [1:0]        cur_seg,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_write <= 1'b0;
      cur_mem   <= 1'b0;
      cur_word  <= 1'b0;
      cur_seg   <= '0;
    end else if (accept) begin
      cur_addr  <= req_addr;
      cur_wdata <= req_wdata;
      cur_write <= req_write;
      cur_mem   <= req_mem;
      cur_word  <= req_word;
      cur_seg   <= req_seg;
    end
  end

  // read data is taken on the edge that ends the last T3/Tw
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= sample_ev && !cur_write;
      if (sample_ev && !cur_write) rd_data <= ad_in;
    end
  end

endmodule

// File: rtl/mbus_den.sv
`timescale 1ns/1ps
module mbus_den
  import mbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  bus_st_e state,
  output logic    data_en_n
);

  // sampled on the falling edge: enable spans mid-T2 to mid-T4
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) data_en_n <= 1'b1;
    else        data_en_n <= !in_strobe(state);
  end

endmodule

// File: rtl/mbus_drive.sv
`timescale 1ns/1ps
module mbus_drive
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  bus_st_e                  state,
  input  logic                     accept,
  input  logic                     req_mem,
  input  logic [ADDR_W-1:0]        cur_addr,
  input  logic [DATA_W-1:0]        cur_wdata,
  input  logic                     cur_write,
  input  logic                     cur_mem,
  input  logic                     cur_word,
  input  logic [1:0]               cur_seg,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic                     bhe_n,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     dir_tx,
  output logic                     mem_sel,
  output logic                     ctl_oe,
  output logic                     hold_ack
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic t1, dat, stb;

  assign t1  = (state == ST_T1);
  assign dat = in_data(state);
  assign stb = in_strobe(state);

  assign ale      = t1;
  assign rd_n     = !(stb && !cur_write);
  assign wr_n     = !(stb && cur_write);
  assign dir_tx   = in_cycle(state) && cur_write;
  assign ad_oe    = t1 || (dat && cur_write);
  assign ad_out   = t1 ? cur_addr[DATA_W-1:0] : ((dat && cur_write) ? cur_wdata : '0);
  assign bhe_n    = in_cycle(state) ? lane_bhe_n(cur_word, cur_addr[0]) : 1'b1;
  assign mem_sel  = (is_boundary(state) && accept) ? req_mem : cur_mem;
  assign ctl_oe   = (state != ST_HOLD);
  assign hold_ack = (state == ST_HOLD);

  for (genvar g = 0; g < HI_W; g++) begin : g_hi
    logic stat_bit;
    if (g < 2) begin : g_seg
      assign stat_bit = cur_seg[g];
    end else begin : g_zero
      assign stat_bit = 1'b0;
    end
    assign a_hi[g] = t1  ? (cur_mem & cur_addr[DATA_W+g]) :
                     dat ? stat_bit : 1'b0;
  end

endmodule

// File: rtl/mbus_seq.sv
`timescale 1ns/1ps
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     req_write,
  input  logic                     req_mem,
  input  logic                     req_word,
  input  logic [1:0]               req_seg,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        ad_out,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic                     bhe_n,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     data_en_n,
  output logic                     dir_tx,
  output logic                     mem_sel,
  input  logic                     ready,
  input  logic                     hold_req,
  output logic                     hold_ack,
  output logic                     ctl_oe
);

  bus_st_e           state;
  logic              accept, sample_ev;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic              cur_write, cur_mem, cur_word;
  logic [1:0]        cur_seg;

  // named events for the checker
  logic st_t1, st_t3, st_tw, st_t4;
  assign st_t1 = (state == ST_T1);
  assign st_t3 = (state == ST_T3);
  assign st_tw = (state == ST_TW);
  assign st_t4 = (state == ST_T4);

  mbus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hold_req(hold_req),
    .ready(ready), .state(state), .req_ready(req_ready), .accept(accept),
    .sample_ev(sample_ev)
  );

  mbus_reqreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst_n(rst_n), .accept(accept), .sample_ev(sample_ev),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .req_mem(req_mem), .req_word(req_word), .req_seg(req_seg), .ad_in(ad_in),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata), .cur_write(cur_write),
    .cur_mem(cur_mem), .cur_word(cur_word), .cur_seg(cur_seg),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  mbus_den u_den (
    .clk(clk), .rst_n(rst_n), .state(state), .data_en_n(data_en_n)
  );

  mbus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .state(state), .accept(accept), .req_mem(req_mem),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata), .cur_write(cur_write),
    .cur_mem(cur_mem), .cur_word(cur_word), .cur_seg(cur_seg),
    .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .bhe_n(bhe_n), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .dir_tx(dir_tx), .mem_sel(mem_sel),
    .ctl_oe(ctl_oe), .hold_ack(hold_ack)
  );

endmodule

// File: rtl/mbus_seq_chk.sv
`timescale 1ns/1ps
module mbus_seq_chk #(
  parameter int HI_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ale,
  input logic            rd_n,
  input logic            wr_n,
  input logic            ad_oe,
  input logic            ctl_oe,
  input logic            hold_req,
  input logic            hold_ack,
  input logic            ready,
  input logic [HI_W-1:0] a_hi,
  input logic            mem_sel,
  input logic            accept,
  input logic            st_t3,
  input logic            st_tw,
  input logic            st_t4
);

  // R2
  ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R2
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ale);

  // R10
  wait_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_t3 || st_tw) && !ready) |=> st_tw);

  // R10
  wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_t3 || st_tw) && ready) |=> st_t4);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R3
  io_upper_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && !mem_sel) |-> (a_hi == '0));

  // R11
  hold_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> $past(hold_req));

  // R12
  hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (!ad_oe && !ctl_oe && !ale));

  // R12
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && !hold_req) |=> !hold_ack);

endmodule

bind mbus_seq mbus_seq_chk #(.HI_W(ADDR_W-DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .ad_oe(ad_oe), .ctl_oe(ctl_oe), .hold_req(hold_req), .hold_ack(hold_ack),
  .ready(ready), .a_hi(a_hi), .mem_sel(mem_sel), .accept(accept),
  .st_t3(st_t3), .st_tw(st_tw), .st_t4(st_t4)
);

// File: tb/mbus_seq_bench.sv
`timescale 1ns/1ps
module mbus_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_write = 1'b0, req_mem = 1'b0, req_word = 1'b0;
  logic [1:0]  req_seg = '0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic [15:0] ad_out;
  logic [15:0] ad_in = '0;
  logic        ad_oe;
  logic [3:0]  a_hi;
  logic        bhe_n, ale, rd_n, wr_n, data_en_n, dir_tx, mem_sel;
  logic        ready = 1'b1;
  logic        hold_req = 1'b0;
  logic        hold_ack, ctl_oe;

  always #2 clk = ~clk;

  mbus_seq u_mbus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .req_mem(req_mem), .req_word(req_word), .req_seg(req_seg),
    .rd_data(rd_data), .rd_valid(rd_valid), .ad_out(ad_out), .ad_in(ad_in),
    .ad_oe(ad_oe), .a_hi(a_hi), .bhe_n(bhe_n), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .data_en_n(data_en_n), .dir_tx(dir_tx), .mem_sel(mem_sel),
    .ready(ready), .hold_req(hold_req), .hold_ack(hold_ack), .ctl_oe(ctl_oe)
  );

  typedef struct {
    logic [19:0] addr;
    logic [15:0] data;
    logic        write, mem, word;
    logic [1:0]  seg;
    int          nwait;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  int   done_cnt = 0;
  int   act_nwait = 0;
  bit   finished = 1'b0;

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // READY generator: low for the requested number of samples at T3/Tw ends
  int kk = 0;
  always @(negedge clk) begin
    if (!rd_n || !wr_n) kk++;
    else kk = 0;
    ready = !(kk >= 2 && kk < 2 + act_nwait);
  end

  // monitor: rebuilds each cycle from the pins and compares with the queue
  bit   busy = 1'b0;
  exp_t cur;
  int   scnt = 0;
  always @(posedge clk) begin
    #3;
    if (rst_n && ale) begin
      if (q.size() == 0) chk("R2", "ale without request", 1, 0);
      else begin
        cur = q.pop_front();
        busy = 1'b1; scnt = 0; act_nwait = cur.nwait; ad_in = cur.data;
        chk("R3", "T1 ad_oe", ad_oe, 1);
        chk("R3", "T1 low address", ad_out, cur.addr[15:0]);
        chk("R3", "T1 upper lines", a_hi, cur.mem ? cur.addr[19:16] : 4'h0);
        chk("R5", "lane code", {bhe_n, ad_out[0]},
            {~(cur.word | cur.addr[0]), cur.addr[0]});
        chk("R8", "T1 dir_tx", dir_tx, cur.write);
        chk("R8", "T1 data_en_n", data_en_n, 1);
        chk("R9", "T1 mem_sel", mem_sel, cur.mem);
        chk("R6", "T1 strobes idle", {rd_n, wr_n}, 2'b11);
      end
    end else if (rst_n && busy) begin
      if (cur.write ? !wr_n : !rd_n) begin
        scnt++;
        chk("R2", "ale single cycle", ale, 0);
        chk("R2", "no accept mid-cycle", req_ready, 0);
        chk("R4", "status code", a_hi, {2'b00, cur.seg});
        chk("R8", "data_en_n in strobe", data_en_n, 0);
        chk("R8", "dir_tx", dir_tx, cur.write);
        chk("R9", "mem_sel", mem_sel, cur.mem);
        if (cur.write) begin
          chk("R7", "write ad_oe", ad_oe, 1);
          chk("R7", "write data", ad_out, cur.data);
        end else
          chk("R6", "read ad_oe", ad_oe, 0);
      end else begin
        chk("R10", "strobe cycles", scnt, 2 + cur.nwait);
        chk("R4", "T4 status", a_hi, {2'b00, cur.seg});
        chk("R8", "data_en_n after mid-T4", data_en_n, 1);
        if (cur.write) begin
          chk("R7", "T4 write data", {ad_oe, ad_out}, {1'b1, cur.data});
        end else begin
          chk("R6", "rd_valid in T4", rd_valid, 1);
          chk("R6", "read data", rd_data, cur.data);
        end
        busy = 1'b0;
        done_cnt++;
      end
    end
  end

  task automatic issue(input logic [19:0] a, input logic [15:0] d,
                       input bit w, input bit m, input bit wd,
                       input logic [1:0] s, input int nw);
    exp_t e;
    e.addr = a; e.data = d; e.write = w; e.mem = m; e.word = wd;
    e.seg = s; e.nwait = nw;
    q.push_back(e);
    req_addr = a; req_wdata = d; req_write = w; req_mem = m;
    req_word = wd; req_seg = s; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    #1 chk("R9", "mem_sel before T1", mem_sel, m);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int n);
    while (done_cnt < n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset strobes", {ale, rd_n, wr_n, data_en_n}, 4'b0111);
    chk("R1", "reset enables", {ad_oe, hold_ack, ctl_oe}, 3'b001);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1", "idle after reset", {ale, rd_n, wr_n, data_en_n, ad_oe, hold_ack, ctl_oe, req_ready},
        8'b0111_0011);
    @(negedge clk);

    // word read, memory, data segment, no wait
    issue(20'hA_1234, 16'hBEEF, 0, 1, 1, 2'b11, 0); wait_done(1);
    // byte write at odd address, stack segment, one wait
    issue(20'h3_0057, 16'h5A00, 1, 1, 0, 2'b01, 1); wait_done(2);
    // IO byte read at even address, code segment, three waits
    issue(20'hF_0F10, 16'h00C3, 0, 0, 0, 2'b10, 3); wait_done(3);
    // back to back: second taken in T4 of the first
    issue(20'h7_8AB2, 16'h1357, 1, 1, 1, 2'b00, 0);
    issue(20'h2_4441, 16'h9ABC, 0, 1, 0, 2'b11, 2); wait_done(5);
    // IO word write
    issue(20'h0_0300, 16'h4321, 1, 0, 1, 2'b10, 0); wait_done(6);

    // R11 / R12: hold in idle
    @(negedge clk);
    hold_req = 1'b1;
    #1;
    chk("R11", "no grant before edge", hold_ack, 0);
    chk("R11", "req_ready blocked by hold", req_ready, 0);
    @(negedge clk); #1;
    chk("R12", "granted and floated", {hold_ack, ctl_oe, ad_oe, ale}, 4'b1000);
    @(negedge clk);
    hold_req = 1'b0;
    @(negedge clk); #1;
    chk("R12", "released", {hold_ack, ctl_oe}, 2'b01);
    @(negedge clk);

    // R11: hold raised mid-cycle, with a request pending
    issue(20'h5_1110, 16'h6789, 0, 1, 1, 2'b01, 2);
    hold_req = 1'b1;
    fork
      issue(20'h6_2222, 16'h2468, 1, 0, 1, 2'b00, 0);
    join_none
    wait (done_cnt == 7);
    chk("R11", "no grant inside cycle", hold_ack, 0);
    @(posedge clk); #3;
    chk("R11", "grant after T4 over request", {hold_ack, ale}, 2'b10);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #3;
      chk("R12", "held and floated", {hold_ack, ctl_oe, ad_oe, ale}, 4'b1000);
    end
    @(negedge clk);
    hold_req = 1'b0;
    @(negedge clk); #1;
    chk("R12", "hold dropped", {hold_ack, ctl_oe}, 2'b01);
    wait_done(8);
    repeat (3) @(negedge clk);
    chk("R2", "queue drained", q.size(), 0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule